// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit timer/counters for a small microcontroller. Software sets them up through a byte-wide register bus carrying a mode register, a control register and four count bytes. Each counter advances either on a shared internal tick strobe (the oscillator divided by 12, produced outside the block) or on falling edges of its own external count pin. Counting can be gated by an external interrupt pin.

Each counter has four modes: a 13-bit counter built from a 5-bit prescaler and an 8-bit count, a plain 16-bit counter, an 8-bit counter that reloads itself from a holding byte, and a split mode. In split mode timer 0 becomes two independent 8-bit counters that drive both overflow flags, and timer 1 holds its value. A cascade option joins both counters into one 32-bit counter. The two overflow flags go to an interrupt controller, which clears each one with an acknowledge pulse. Timer 1's overflow is also exported as a one-cycle strobe for a serial port's baud-rate logic.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset the mode register, control register, all four count bytes, both flags and the overflow strobe read as zero.
- R2: The bus address selects a register: 0 is mode, 1 is control, 2 and 3 are timer 0 low and high, 4 and 5 are timer 1 low and high. Any other address reads 0. Control bit 0 is run0, bit 1 is run1 and bit 2 is cascade; control bits 7..3 read 0. A write takes effect at the next clock edge and overrides any count update of that byte in the same cycle. Reads are combinational.
- R3: The mode register holds timer 0 in bits 3..0 and timer 1 in bits 7..4. Within each nibble, bits 1..0 are the mode, bit 2 is external select and bit 3 is gate. In mode 1 the 16-bit count goes up by one per count event. On a wrap from 0xFFFF to 0x0000 the timer's flag is set from the next cycle.
- R4: In mode 0 the count is the 13-bit value {high byte, low[4:0]}. Low bits 7..5 are never changed by counting. Overflow happens when all 13 bits are ones.
- R5: In mode 2 the low byte counts. On an event at 0xFF it reloads from the high byte and overflows. Counting never changes the high byte.
- R6: With timer 0 in mode 3, its low byte is an 8-bit counter under timer 0's controls that sets flag0. Its high byte counts every tick while run1 is 1 and sets flag1. Timer 1's own overflow then does not set flag1, but it still drives the strobe.
- R7: A timer 1 in mode 3, outside cascade, never counts.
- R8: With external select 0 each tick is an event. With external select 1 an event happens on a tick where the pin sampled at the previous tick was 1 and is now 0. The pin is sampled only on ticks, and the sample history is 0 after reset.
- R9: A timer counts only while its run bit is 1. When its gate bit is 1, it also needs its gate pin to be 1.
- R10: With cascade set, {timer 1, timer 0} is one 32-bit counter driven by timer 0's event and run/gate controls, and the mode fields are ignored. The carry out of bit 31 sets flag1 and the strobe, and flag0 is not set.
- R11: An overflow sets the flag. An acknowledge clears it. If both happen in the same cycle, the flag stays set.
- R12: The strobe is high for exactly the cycle after each timer 1 overflow, or after each cascade carry. Back-to-back overflows keep it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Internal count tick strobe |
| cnt_pin0 | input | 1 | Timer 0 external count pin |
| cnt_pin1 | input | 1 | Timer 1 external count pin |
| gate_pin0 | input | 1 | Timer 0 gate (interrupt) pin |
| gate_pin1 | input | 1 | Timer 1 gate (interrupt) pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ack0 | input | 1 | Acknowledge for flag 0 |
| ack1 | input | 1 | Acknowledge for flag 1 |
| flag0 | output | 1 | Timer 0 overflow flag |
| flag1 | output | 1 | Timer 1 overflow flag |
| t1_ovf_pulse | output | 1 | Timer 1 overflow strobe for baud logic |

## Verification
The hardest case to reach is the one where two sources compete for flag1. In split mode, timer 0's high byte overflows under run1 while timer 1, in another mode, overflows near the same time. The flag must follow only the first source and the strobe only the second. The stimulus preloads both counters a few counts short of wrapping, runs them together, then acknowledges and checks that only the split high byte sets flag1 again. Cascade carry and the overlap of acknowledge with a new overflow are reached the same way, with near-full preloads and an acknowledge held high while a reloading counter overflows on every tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam int A_MODE = 0;
  localparam int A_CTL  = 1;
  localparam int A_LO0  = 2;
  localparam int A_HI0  = 3;
  localparam int A_LO1  = 4;
  localparam int A_HI1  = 5;

  typedef enum logic [1:0] {
    M_PRE13   = 2'd0,
    M_FULL16  = 2'd1,
    M_RELOAD8 = 2'd2,
    M_SPLIT   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  // 8-bit increment with carry out in the top bit
  function automatic logic [BYTE_W:0] tmr_inc8(input logic [BYTE_W-1:0] v);
    return {1'b0, v} + {{BYTE_W{1'b0}}, 1'b1};
  endfunction

  // one count step of a whole timer; result is {overflow, next value}
  function automatic logic [CNT_W:0] tmr_advance(input logic [CNT_W-1:0] v,
                                                 input tmr_mode_e m);
    logic [BYTE_W+PRE_W:0] p;
    logic [CNT_W:0]        r;
    p = '0;
    case (m)
      M_PRE13: begin
        p = {1'b0, v[CNT_W-1:BYTE_W], v[PRE_W-1:0]} + 1'b1;
        r = {p[BYTE_W+PRE_W], p[BYTE_W+PRE_W-1:PRE_W], v[BYTE_W-1:PRE_W], p[PRE_W-1:0]};
      end
      M_RELOAD8: begin
        if (v[BYTE_W-1:0] == {BYTE_W{1'b1}})
          r = {1'b1, v[CNT_W-1:BYTE_W], v[CNT_W-1:BYTE_W]};
        else
          r = {1'b0, v[CNT_W-1:BYTE_W], v[BYTE_W-1:0] + 1'b1};
      end
      M_FULL16: r = {1'b0, v} + 1'b1;
      default:  r = {1'b0, v};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_evt.sv
module tmr_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ext_pin,
  input  logic gate_pin,
  input  logic run,
  input  logic ext_sel,
  input  logic gate_en,
  output logic step
);
  logic prev_q;
  logic fall_seen;
  logic allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= 1'b0;
    else if (tick) prev_q <= ext_pin;
  end

  assign fall_seen = tick & prev_q & ~ext_pin;
  assign allowed   = run & (~gate_en | gate_pin);
  assign step      = allowed & (ext_sel ? fall_seen : tick);

  // R8
  ext_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && !tick) |-> !step);
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (ack)  flag <= 1'b0;
  end

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  // R11
  flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !flag);
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_pin0,
  input  logic              cnt_pin1,
  input  logic              gate_pin0,
  input  logic              gate_pin1,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ack0,
  input  logic              ack1,
  output logic              flag0,
  output logic              flag1,
  output logic              t1_ovf_pulse
);
  import tmr_pkg::*;

  localparam int NT = 2;

  logic [2*4-1:0]     mode_q;
  logic [2:0]         ctl_q;
  logic [CNT_W-1:0]   cnt0_q, cnt1_q, nx0, nx1;
  tmr_cfg_t           cfg [NT];
  logic [NT-1:0]      step;
  logic [NT-1:0]      cnt_pin, gate_pin;
  logic               step_hi, casc;
  logic               wr_mode, wr_ctl, wr_lo0, wr_hi0, wr_lo1, wr_hi1;
  // named internal overflow events
  logic               ovf_t0, ovf_t1, ovf_split_hi, ovf_casc;
  logic               set_f0, set_f1;
  logic [CNT_W:0]     r0, r1;
  logic [BYTE_W:0]    lo_s, hi_s;
  logic [2*CNT_W:0]   sum32;

  assign cnt_pin  = {cnt_pin1, cnt_pin0};
  assign gate_pin = {gate_pin1, gate_pin0};
  assign casc     = ctl_q[2];
  assign step_hi  = tick & ctl_q[1];

  assign wr_mode = bus_we && (int'(bus_addr) == A_MODE);
  assign wr_ctl  = bus_we && (int'(bus_addr) == A_CTL);
  assign wr_lo0  = bus_we && (int'(bus_addr) == A_LO0);
  assign wr_hi0  = bus_we && (int'(bus_addr) == A_HI0);
  assign wr_lo1  = bus_we && (int'(bus_addr) == A_LO1);
  assign wr_hi1  = bus_we && (int'(bus_addr) == A_HI1);

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign cfg[i] = tmr_cfg_t'(mode_q[4*i +: 4]);
    tmr_evt u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ext_pin  (cnt_pin[i]),
      .gate_pin (gate_pin[i]),
      .run      (ctl_q[i]),
      .ext_sel  (cfg[i].ext_sel),
      .gate_en  (cfg[i].gate),
      .step     (step[i])
    );
  end

  always_comb begin
    nx0 = cnt0_q;
    nx1 = cnt1_q;
    ovf_t0 = 1'b0;
    ovf_t1 = 1'b0;
    ovf_split_hi = 1'b0;
    ovf_casc = 1'b0;
    r0 = tmr_advance(cnt0_q, cfg[0].mode);
    r1 = tmr_advance(cnt1_q, cfg[1].mode);
    lo_s = tmr_inc8(cnt0_q[BYTE_W-1:0]);
    hi_s = tmr_inc8(cnt0_q[CNT_W-1:BYTE_W]);
    sum32 = {1'b0, cnt1_q, cnt0_q} + 1'b1;
    if (casc) begin
      if (step[0]) begin
        {nx1, nx0} = sum32[2*CNT_W-1:0];
        ovf_casc = sum32[2*CNT_W];
      end
    end else begin
      if (cfg[0].mode == M_SPLIT) begin
        if (step[0]) begin
          nx0[BYTE_W-1:0] = lo_s[BYTE_W-1:0];
          ovf_t0 = lo_s[BYTE_W];
        end
        if (step_hi) begin
          nx0[CNT_W-1:BYTE_W] = hi_s[BYTE_W-1:0];
          ovf_split_hi = hi_s[BYTE_W];
        end
      end else if (step[0]) begin
        nx0 = r0[CNT_W-1:0];
        ovf_t0 = r0[CNT_W];
      end
      if (cfg[1].mode != M_SPLIT && step[1]) begin
        nx1 = r1[CNT_W-1:0];
        ovf_t1 = r1[CNT_W];
      end
    end
    if (wr_lo0) nx0[BYTE_W-1:0]     = bus_wdata;
    if (wr_hi0) nx0[CNT_W-1:BYTE_W] = bus_wdata;
    if (wr_lo1) nx1[BYTE_W-1:0]     = bus_wdata;
    if (wr_hi1) nx1[CNT_W-1:BYTE_W] = bus_wdata;
  end

  assign set_f0 = ovf_t0;
  assign set_f1 = casc ? ovf_casc : ((cfg[0].mode == M_SPLIT) ? ovf_split_hi : ovf_t1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= '0;
      ctl_q        <= '0;
      cnt0_q       <= '0;
      cnt1_q       <= '0;
      t1_ovf_pulse <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_ctl)  ctl_q  <= bus_wdata[2:0];
      cnt0_q       <= nx0;
      cnt1_q       <= nx1;
      t1_ovf_pulse <= casc ? ovf_casc : ovf_t1;
    end
  end

  tmr_flag u_flag0 (.clk(clk), .rst_n(rst_n), .set(set_f0), .ack(ack0), .flag(flag0));
  tmr_flag u_flag1 (.clk(clk), .rst_n(rst_n), .set(set_f1), .ack(ack1), .flag(flag1));

  always_comb begin
    case (int'(bus_addr))
      A_MODE:  bus_rdata = mode_q;
      A_CTL:   bus_rdata = {5'b0, ctl_q};
      A_LO0:   bus_rdata = cnt0_q[BYTE_W-1:0];
      A_HI0:   bus_rdata = cnt0_q[CNT_W-1:BYTE_W];
      A_LO1:   bus_rdata = cnt1_q[BYTE_W-1:0];
      A_HI1:   bus_rdata = cnt1_q[CNT_W-1:BYTE_W];
      default: bus_rdata = '0;
    endcase
  end

  // R5
  reload_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0].mode == M_RELOAD8 && !casc && !wr_hi0) |=> $stable(cnt0_q[CNT_W-1:BYTE_W]));
  // R7
  t1_split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1].mode == M_SPLIT && !casc && !wr_lo1 && !wr_hi1) |=> $stable(cnt1_q));
  // R9
  run_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[0] && !wr_lo0) |=> $stable(cnt0_q[BYTE_W-1:0]));
  // R12
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_t1 && !ovf_casc) |=> !t1_ovf_pulse);
endmodule

// File: tb/tb_dual_timer_unit.sv
`timescale 1ns/100ps
module tb_dual_timer_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, cnt_pin0 = 0, cnt_pin1 = 0, gate_pin0 = 0, gate_pin1 = 0;
  logic bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ack0 = 0, ack1 = 0;
  logic flag0, flag1, t1_ovf_pulse;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dual_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin0(cnt_pin0), .cnt_pin1(cnt_pin1),
    .gate_pin0(gate_pin0), .gate_pin1(gate_pin1), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack0(ack0), .ack1(ack1),
    .flag0(flag0), .flag1(flag1), .t1_ovf_pulse(t1_ovf_pulse)
  );

  // stimulus held for the next cycle
  bit g_tick, g_e0, g_e1, g_gp0, g_gp1, g_ack0, g_ack1, g_we;
  bit [2:0] g_ad;
  bit [7:0] g_wd;

  // reference model state
  int m_c0, m_c1;
  bit [7:0] m_mode;
  bit [2:0] m_ctl;
  bit m_p0, m_p1, m_f0, m_f1, m_st;

  task automatic check(input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  function automatic int adv(input int v, input int m, output bit o);
    int lo, hi, p;
    lo = v % 256; hi = v / 256; o = 0;
    case (m)
      0: begin
        p = hi * 32 + lo % 32 + 1;
        if (p == 8192) begin p = 0; o = 1; end
        return (p / 32) * 256 + (lo / 32) * 32 + p % 32;
      end
      1: begin
        p = v + 1;
        if (p == 65536) begin p = 0; o = 1; end
        return p;
      end
      2: begin
        if (lo == 255) begin o = 1; return hi * 256 + hi; end
        return v + 1;
      end
      default: return v;
    endcase
  endfunction

  task automatic model_update();
    int md0, md1, n0, n1, lo0, hi0;
    bit s0, s1, sh, o0, o1, os, o32, casc;
    longint big;
    md0 = int'(m_mode[1:0]); md1 = int'(m_mode[5:4]);
    casc = m_ctl[2];
    s0 = m_ctl[0] && (!m_mode[3] || g_gp0) && (m_mode[2] ? (g_tick && m_p0 && !g_e0) : g_tick);
    s1 = m_ctl[1] && (!m_mode[7] || g_gp1) && (m_mode[6] ? (g_tick && m_p1 && !g_e1) : g_tick);
    sh = g_tick && m_ctl[1];
    o0 = 0; o1 = 0; os = 0; o32 = 0;
    n0 = m_c0; n1 = m_c1;
    lo0 = m_c0 % 256; hi0 = m_c0 / 256;
    if (casc) begin
      if (s0) begin
        big = longint'(m_c1) * 65536 + longint'(m_c0) + 1;
        if (big == 64'h1_0000_0000) begin big = 0; o32 = 1; end
        n1 = int'(big / 65536); n0 = int'(big % 65536);
      end
    end else begin
      if (md0 == 3) begin
        if (s0) begin lo0 = lo0 + 1; if (lo0 == 256) begin lo0 = 0; o0 = 1; end end
        if (sh) begin hi0 = hi0 + 1; if (hi0 == 256) begin hi0 = 0; os = 1; end end
        n0 = hi0 * 256 + lo0;
      end else if (s0) n0 = adv(m_c0, md0, o0);
      if (md1 != 3 && s1) n1 = adv(m_c1, md1, o1);
    end
    if (g_we) begin
      case (g_ad)
        3'd0: m_mode = g_wd;
        3'd1: m_ctl = g_wd[2:0];
        3'd2: n0 = (n0 / 256) * 256 + int'(g_wd);
        3'd3: n0 = int'(g_wd) * 256 + n0 % 256;
        3'd4: n1 = (n1 / 256) * 256 + int'(g_wd);
        3'd5: n1 = int'(g_wd) * 256 + n1 % 256;
        default: ;
      endcase
    end
    m_c0 = n0; m_c1 = n1;
    if (g_tick) begin m_p0 = g_e0; m_p1 = g_e1; end
    m_f0 = o0 ? 1'b1 : (g_ack0 ? 1'b0 : m_f0);
    if (casc ? o32 : (md0 == 3 ? os : o1)) m_f1 = 1'b1;
    else if (g_ack1) m_f1 = 1'b0;
    m_st = casc ? o32 : o1;
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return int'(m_mode);
      1: return int'(m_ctl);
      2: return m_c0 % 256;
      3: return m_c0 / 256;
      4: return m_c1 % 256;
      5: return m_c1 / 256;
      default: return 0;
    endcase
  endfunction

  task automatic compare_all();
    bus_we = 0;
    for (int a = 0; a < 7; a++) begin
      bus_addr = a[2:0];
      #0.1;
      check(int'(bus_rdata), exp_rd(a), $sformatf("reg%0d", a));
    end
    check(int'(flag0), int'(m_f0), "flag0");
    check(int'(flag1), int'(m_f1), "flag1");
    check(int'(t1_ovf_pulse), int'(m_st), "strobe");
  endtask

  task automatic step();
    @(negedge clk);
    tick = g_tick; cnt_pin0 = g_e0; cnt_pin1 = g_e1; gate_pin0 = g_gp0; gate_pin1 = g_gp1;
    ack0 = g_ack0; ack1 = g_ack1; bus_we = g_we; bus_addr = g_ad; bus_wdata = g_wd;
    @(posedge clk);
    model_update();
    #1;
    compare_all();
    g_we = 0; g_ack0 = 0; g_ack1 = 0;
  endtask

  task automatic wr(input int a, input int d);
    g_we = 1; g_ad = a[2:0]; g_wd = d[7:0];
    step();
  endtask

  task automatic run(input int n, input bit tk);
    for (int i = 0; i < n; i++) begin g_tick = tk; step(); end
    g_tick = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    for (int a = 0; a < 6; a++) begin
      bus_addr = a[2:0];
      #0.1;
      check(int'(bus_rdata), 0, $sformatf("reset reg%0d", a));
    end
    check(int'(flag0), 0, "reset flag0");
    check(int'(flag1), 0, "reset flag1");
    check(int'(t1_ovf_pulse), 0, "reset strobe");
    @(negedge clk);
    rst_n = 1;
    run(2, 1);

    cur_req = "R2";
    wr(1, 8'hFF);            // only low 3 bits stick
    wr(1, 0);
    wr(6, 8'h5A);            // unmapped address
    cur_req = "R3";
    wr(0, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 1);
    run(4, 1);
    g_ack0 = 1; step();      // R11 clear
    cur_req = "R2";
    g_tick = 1; wr(2, 8'h40); // write overrides increment in same cycle
    run(3, 1);

    cur_req = "R4";
    wr(1, 0); wr(0, 8'h00); wr(2, 8'hFD); wr(3, 8'hFF); wr(1, 1);
    for (int i = 0; i < 8; i++) begin g_tick = i[0]; step(); end
    g_ack0 = 1; step();

    cur_req = "R5";
    wr(1, 0); wr(0, 8'h02); wr(3, 8'hF0); wr(2, 8'hFD); wr(1, 1);
    run(20, 1);

    cur_req = "R6";
    wr(1, 0); wr(0, 8'h33); wr(2, 8'hFE); wr(3, 8'hFD); wr(4, 8'h12); wr(5, 8'h34);
    g_ack0 = 1; g_ack1 = 1; step();
    wr(1, 3);
    cur_req = "R7";
    run(6, 1);
    cur_req = "R6";
    wr(1, 0); wr(0, 8'h13); wr(4, 8'hFE); wr(5, 8'hFF); wr(3, 8'hF0);
    g_ack0 = 1; g_ack1 = 1; step();
    wr(1, 2);                 // run1 only: t1 counts, t0 high byte counts
    run(4, 1);
    g_ack1 = 1; step();
    run(16, 1);

    cur_req = "R9";
    wr(1, 0); wr(0, 8'h09); wr(2, 0); wr(3, 0); wr(1, 1);
    g_gp0 = 0; run(5, 1);
    g_gp0 = 1; run(5, 1);
    g_gp0 = 0; run(3, 1);

    cur_req = "R8";
    wr(1, 0); wr(0, 8'hD5); wr(2, 0); wr(3, 0); wr(4, 0); wr(5, 0); wr(1, 3);
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      g_tick = lfsr[0] | lfsr[5];
      g_e0 = lfsr[1]; g_e1 = lfsr[2]; g_gp1 = lfsr[3] | lfsr[7];
      step();
    end
    g_tick = 0; g_e0 = 0; g_e1 = 0; g_gp1 = 0;

    cur_req = "R10";
    wr(1, 0); wr(0, 8'h22); wr(2, 8'hFE); wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
    g_ack0 = 1; g_ack1 = 1; step();
    wr(1, 5);
    run(5, 1);

    cur_req = "R11";
    wr(1, 0); wr(0, 8'h22); wr(3, 8'hFF); wr(2, 8'hFE); wr(5, 8'hFF); wr(4, 8'hFE);
    wr(1, 3);
    for (int i = 0; i < 6; i++) begin g_tick = 1; g_ack0 = 1; g_ack1 = 1; step(); end
    cur_req = "R12";
    run(4, 1);
    g_ack0 = 1; g_ack1 = 1; step();
    run(3, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule